// File: doc/BRIEF.md
# Dual I2C Controller Soft-Clear Register

This block is an 8-bit, memory-mapped control register that lets software reset the internal state of two I2C controller instances. It has no storage of its own. A full-byte write to the selected register is decoded at once. Its low nibble is matched against a small set of command codes. A recognised code gives a one-cycle clear pulse on the clear output of controller 0, of controller 1, or of both.

Any other code is refused. A refused code raises a one-cycle error indication and no clear output. Reads always return a fixed pattern: the upper nibble reads as zeros and the command nibble reads as ones, whatever was written before.

The controllers themselves are outside this block. They are seen here only as two clear outputs. All outputs are registered, so each result appears on the clock edge that follows the strobe.

Top module: `ctl_clear_reg`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `clr0`, `clr1`, `codeErr` are 0 and `rdata` is 0x00. The first read after reset returns 0x0F.
- R2: When `sel` and `rdEn` are high at a clock edge, `rdata` shows 0x0F after that edge: bits 7..4 are 0 and bits 3..0 are 1, regardless of earlier writes. On every other cycle `rdata` is 0x00.
- R3: A read strobe never raises `clr0`, `clr1` or `codeErr`.
- R4: A selected write whose data bits 3..0 equal 0101 raises `clr0` alone, for exactly the one cycle after the write edge.
- R5: A selected write whose bits 3..0 equal 0110 raises `clr1` alone, for exactly the one cycle after the write edge.
- R6: A selected write whose bits 3..0 equal 0111 raises both `clr0` and `clr1` for exactly the one cycle after the write edge.
- R7: A selected write whose bits 3..0 are one of 0000, 0001, 0010, 0011 or 0100 raises `codeErr` for one cycle and no clear output.
- R8: A selected write whose bit 3 is 1 (codes 1000 to 1111) raises `codeErr` for one cycle and no clear output.
- R9: Selected writes on consecutive cycles each produce their own result in the cycle after their own edge. Nothing is merged and nothing is lost.
- R10: A write or read strobe with `sel` low changes no output.
- R11: Data bits 7..4 of a write have no effect on the decode. Only bits 3..0 select the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register select from the address decoder |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data; bits 3..0 carry the command code |
| rdata | output | 8 | Read data, valid the cycle after a selected read |
| clr0 | output | 1 | One-cycle clear pulse to controller 0 |
| clr1 | output | 1 | One-cycle clear pulse to controller 1 |
| codeErr | output | 1 | One-cycle flag for a prohibited or invalid code |

## Verification
The bench sweeps all sixteen command codes, so it finds a decoder that treats 0100 or any code with bit 3 set as a clear, or that routes a code to the wrong controller. It writes codes back to back, so a design that stretches a pulse or drops the second of two writes gives the wrong pulse count. It writes with junk in the reserved nibble and with the select low, which exposes a decode that looks at too many bits or ignores the select. It reads right after writes, which catches read data that echoes the written code instead of the fixed pattern, and any read that fires a clear.

// File: rtl/ctl_clear_pkg.sv
package ctl_clear_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = 4;
  localparam int NUM_CTRL = 2;

  typedef struct packed {
    logic [NUM_CTRL-1:0] clrHit;
    logic                errHit;
    logic                rdHit;
  } clrStrobe_t;
endpackage

// File: rtl/ctl_clear_ctrl.sv
module ctl_clear_ctrl
  import ctl_clear_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          sel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wdata,
  output clrStrobe_t    strobe
);
  logic [CODE_W-1:0]   code;
  logic                wrHit;
  logic                codeOk;
  logic [NUM_CTRL-1:0] target;

  assign code  = wdata[CODE_W-1:0];
  assign wrHit = sel & wrEn;

  // code form: 0 1 c1 c0, at least one target bit set
  assign target = code[NUM_CTRL-1:0];
  assign codeOk = (code[3] == 1'b0) && (code[2] == 1'b1) && (|target);

  always_comb begin
    strobe        = '0;
    strobe.rdHit  = sel & rdEn;
    if (wrHit) begin
      if (codeOk) strobe.clrHit = target;
      else        strobe.errHit = 1'b1;
    end
  end
endmodule

// File: rtl/ctl_clear_dp.sv
module ctl_clear_dp
  import ctl_clear_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  clrStrobe_t          strobe,
  output logic [DW-1:0]       rdata,
  output logic [NUM_CTRL-1:0] clrOut,
  output logic                errOut
);
  localparam logic [DW-1:0] READ_VAL = {{(DW-CODE_W){1'b0}}, {CODE_W{1'b1}}};

  genvar g;
  generate
    for (g = 0; g < NUM_CTRL; g++) begin : gClr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) clrOut[g] <= 1'b0;
        else       clrOut[g] <= strobe.clrHit[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errOut <= 1'b0;
      rdata  <= '0;
    end else begin
      errOut <= strobe.errHit;
      rdata  <= strobe.rdHit ? READ_VAL : '0;
    end
  end
endmodule

// File: rtl/ctl_clear_reg.sv
module ctl_clear_reg
  import ctl_clear_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              clr0,
  output logic              clr1,
  output logic              codeErr
);
  clrStrobe_t          strobe;
  logic [NUM_CTRL-1:0] clrVec;

  ctl_clear_ctrl #(.DW(DATA_W)) uCtrl (
    .sel(sel), .wrEn(wrEn), .rdEn(rdEn), .wdata(wdata), .strobe(strobe)
  );

  ctl_clear_dp #(.DW(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdata(rdata), .clrOut(clrVec), .errOut(codeErr)
  );

  assign clr0 = clrVec[0];
  assign clr1 = clrVec[1];
endmodule

// File: rtl/ctl_clear_chk.sv
module ctl_clear_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sel,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       clr0,
  input logic       clr1,
  input logic       codeErr
);
  // R4 R6
  clr0_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr0 |-> $past(sel && wrEn && (wdata[3:0] == 4'b0101 || wdata[3:0] == 4'b0111)));

  // R5 R6
  clr1_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr1 |-> $past(sel && wrEn && (wdata[3:0] == 4'b0110 || wdata[3:0] == 4'b0111)));

  // R7 R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> (!clr0 && !clr1 && $past(sel && wrEn)));

  // R2
  rd_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(sel && rdEn) |-> (rdata == 8'h0F));

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sel && rdEn) |-> (rdata == 8'h00));

  // R3
  rd_noclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(sel && rdEn && !wrEn) |-> (!clr0 && !clr1 && !codeErr));
endmodule

bind ctl_clear_reg ctl_clear_chk uChk (
  .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .rdEn(rdEn),
  .wdata(wdata), .rdata(rdata), .clr0(clr0), .clr1(clr1), .codeErr(codeErr)
);

// File: tb/ctl_clear_reg_test.sv
`timescale 1ns/1ps
module ctl_clear_reg_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       clr0, clr1, codeErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected item: {rdata, clr0, clr1, codeErr}
  logic [10:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  ctl_clear_reg uut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .rdEn(rdEn),
    .wdata(wdata), .rdata(rdata), .clr0(clr0), .clr1(clr1), .codeErr(codeErr)
  );

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expectation from the code table in the requirements
  function automatic logic [2:0] decode(input logic [3:0] c);
    case (c)
      4'b0101: return 3'b100;
      4'b0110: return 3'b010;
      4'b0111: return 3'b110;
      default: return 3'b001;
    endcase
  endfunction

  task automatic drive(input logic s, input logic w, input logic r,
                       input logic [7:0] d, input string tag);
    logic [2:0]  res;
    logic [7:0]  rd;
    @(negedge clk);
    sel = s; wrEn = w; rdEn = r; wdata = d;
    res = (s && w) ? decode(d[3:0]) : 3'b000;
    rd  = (s && r) ? 8'h0F : 8'h00;
    expQ.push_back({rd, res});
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 8'h00, "idle");
  endtask

  // monitor: compares each cycle's outputs with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        logic [10:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {rdata, clr0, clr1, codeErr}, e);
      end
    end
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {rdata, clr0, clr1, codeErr}, 11'h0);
    @(negedge clk);
    rstN = 1'b1;
    idle();
    drive(1'b1, 1'b0, 1'b1, 8'h00, "R1 first read after reset");
    idle();
    // R4 R5 R6
    drive(1'b1, 1'b1, 1'b0, 8'h05, "R4 clear ctrl0");
    idle();
    drive(1'b1, 1'b1, 1'b0, 8'h06, "R5 clear ctrl1");
    idle();
    drive(1'b1, 1'b1, 1'b0, 8'h07, "R6 clear both");
    idle();
    // R7 R8 full code sweep
    for (int c = 0; c < 16; c++) begin
      drive(1'b1, 1'b1, 1'b0, 8'(c), (c[3] ? "R8 code sweep" : "R7 code sweep"));
      idle();
    end
    // R9 back to back
    drive(1'b1, 1'b1, 1'b0, 8'h05, "R9 b2b first");
    drive(1'b1, 1'b1, 1'b0, 8'h05, "R9 b2b second");
    drive(1'b1, 1'b1, 1'b0, 8'h06, "R9 b2b third");
    drive(1'b1, 1'b1, 1'b0, 8'h0C, "R9 b2b err");
    drive(1'b1, 1'b1, 1'b0, 8'h07, "R9 b2b both");
    idle();
    // R11 reserved bits ignored
    drive(1'b1, 1'b1, 1'b0, 8'hF5, "R11 reserved F with 0101");
    drive(1'b1, 1'b1, 1'b0, 8'hA6, "R11 reserved A with 0110");
    drive(1'b1, 1'b1, 1'b0, 8'h34, "R11 reserved 3 with 0100");
    idle();
    // R10 unselected
    drive(1'b0, 1'b1, 1'b0, 8'h07, "R10 unselected write");
    drive(1'b0, 1'b0, 1'b1, 8'h00, "R10 unselected read");
    idle();
    // R2 R3 reads after writes
    drive(1'b1, 1'b1, 1'b0, 8'h06, "R2 write before read");
    drive(1'b1, 1'b0, 1'b1, 8'h00, "R2 R3 read after write");
    drive(1'b1, 1'b0, 1'b1, 8'hFF, "R3 read with data");
    drive(1'b1, 1'b1, 1'b1, 8'h05, "R2 read and write same cycle");
    idle();
    idle();
    done = 1'b1;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule